// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host posts one request at a time over a valid/ready handshake: a 17-bit word address, a write flag and a write byte. The controller turns each request into a strobe sequence for the memory. It drives two chip enables of opposite polarity, an output enable, a write enable, the address and a split data bus with a drive-enable. Read data comes back on a byte output, together with a one-cycle valid pulse.

Every interval is held for a whole number of clock cycles. Each count comes from a nanosecond parameter and the clock period, rounded up, with a floor of one cycle. A write is ended by raising the write enable while both chip enables stay active, so data setup is measured against that edge. When a request changes direction (read after write, or write after read), one cycle with every strobe inactive is added before the memory is selected again.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and in every cycle where req_ready is high, the memory is deselected: mem_ce1_n is 1, mem_ce2 is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dout_en is 0.
- R2: req_ready is high only when the controller is idle. A request is taken in the cycle where req_valid and req_ready are both high, and req_ready is low in the next cycle. Address, write flag and write data are captured at that moment, so later changes on those inputs have no effect on the operation.
- R3: A read keeps the memory selected with mem_we_n at 1 and mem_oe_n at 0 for RD = max(ceil(T_RC_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles, each count at least 1. mem_addr does not change while the memory is selected.
- R4: The value on mem_din in the last cycle of the read interval appears on rd_data. rd_valid is high for exactly one cycle, which is the first cycle after mem_oe_n returns to 1.
- R5: A write holds mem_we_n at 0 for PW = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)) cycles, and mem_oe_n stays at 1 whenever mem_we_n is 0.
- R6: The write data is driven (mem_dout_en is 1) from the cycle mem_we_n falls until one cycle after it rises, for PW+1 cycles. In the cycle mem_we_n rises, both chip enables are still active.
- R7: A write keeps the memory selected for SU+PW+1 cycles, where SU = max(1, ceil(T_AW_NS/CLK_NS)-PW, ceil(T_WC_NS/CLK_NS)-PW-1).
- R8: When a request keeps the previous direction, the chip is selected in the first cycle after acceptance. When it changes direction, the chip is selected in the second cycle after acceptance. After reset, the previous direction counts as read.
- R9: mem_dout_en is never 1 while mem_oe_n is 0 or while the memory is deselected.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 8 | Data toward the memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 8 | Data from the memory |

## Verification
A wrong sequencer state shows up within one cycle as a strobe pattern that cannot occur: for example, the data driver on while the output enable is low, or the controller ready while a chip enable is still active. A wrong interval count shows up when the run ends, as a read, write-enable or select run whose length is not the computed count. A wrong capture point shows up later, either as a wrong byte at the rising edge of the write enable or as a wrong value returned by a subsequent read of that address. A missing or extra turnaround shows up as a select latency of one or two cycles that does not match the direction history.

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int T_RC_NS  = 70,
  parameter int T_WC_NS  = 70,
  parameter int T_PWE_NS = 55,
  parameter int T_SD_NS  = 30,
  parameter int T_OE_NS  = 35,
  parameter int T_AW_NS  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(ns2cyc(T_RC_NS), ns2cyc(T_OE_NS));
  localparam int PW_CYC = imax(ns2cyc(T_PWE_NS), ns2cyc(T_SD_NS));
  localparam int SU_CYC = imax(1, imax(ns2cyc(T_AW_NS) - PW_CYC, ns2cyc(T_WC_NS) - PW_CYC - 1));
  localparam int CNT_W  = $clog2(imax(RD_CYC, imax(PW_CYC, SU_CYC)) + 1);

  typedef enum logic [2:0] {
    IDLE, RD_ACCESS, RD_CAPTURE, WR_SETUP, WR_PULSE, WR_END, TURNAROUND
  } state_t;

  state_t             st, st_nx;
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic               last_wr;
  logic               accept;
  logic               sel_nx;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;

  assign accept    = (st == IDLE) && req_valid;
  assign req_ready = (st == IDLE);
  assign rd_valid  = (st == RD_CAPTURE);
  assign rd_data   = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign sel_nx    = (st_nx == RD_ACCESS) || (st_nx == WR_SETUP) ||
                     (st_nx == WR_PULSE)  || (st_nx == WR_END);

  always_comb begin
    st_nx  = st;
    cnt_nx = (cnt != '0) ? cnt - 1'b1 : cnt;
    case (st)
      IDLE:
        if (req_valid) begin
          if (req_write != last_wr) begin
            st_nx = TURNAROUND;
          end else if (req_write) begin
            st_nx  = WR_SETUP;
            cnt_nx = CNT_W'(SU_CYC - 1);
          end else begin
            st_nx  = RD_ACCESS;
            cnt_nx = CNT_W'(RD_CYC - 1);
          end
        end
      TURNAROUND:
        if (last_wr) begin
          st_nx  = WR_SETUP;
          cnt_nx = CNT_W'(SU_CYC - 1);
        end else begin
          st_nx  = RD_ACCESS;
          cnt_nx = CNT_W'(RD_CYC - 1);
        end
      RD_ACCESS:  if (cnt == '0) st_nx = RD_CAPTURE;
      RD_CAPTURE: st_nx = IDLE;
      WR_SETUP:
        if (cnt == '0) begin
          st_nx  = WR_PULSE;
          cnt_nx = CNT_W'(PW_CYC - 1);
        end
      WR_PULSE:   if (cnt == '0) st_nx = WR_END;
      WR_END:     st_nx = IDLE;
      default:    st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      cnt         <= '0;
      last_wr     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      mem_ce1_n   <= 1'b1;
      mem_ce2     <= 1'b0;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout_en <= 1'b0;
    end else begin
      st          <= st_nx;
      cnt         <= cnt_nx;
      mem_ce1_n   <= !sel_nx;
      mem_ce2     <= sel_nx;
      mem_oe_n    <= (st_nx != RD_ACCESS);
      mem_we_n    <= (st_nx != WR_PULSE);
      mem_dout_en <= (st_nx == WR_PULSE) || (st_nx == WR_END);
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        last_wr <= req_write;
      end
      if (st == RD_ACCESS && cnt == '0) rdata_q <= mem_din;
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

  a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dout_en));

  a_r6_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dout_en));

  a_r9_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_oe_n && !mem_ce1_n && mem_ce2));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
  .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dout_en(mem_dout_en)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int CLK_NS = 20, T_RC = 70, T_WC = 70, T_PWE = 55, T_SD = 30, T_OE = 35, T_AW = 60;

  function automatic int cyc(input int ns);
    int c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(cyc(T_RC), cyc(T_OE));
  localparam int E_PW  = mx(cyc(T_PWE), cyc(T_SD));
  localparam int E_SU  = mx(1, mx(cyc(T_AW) - E_PW, cyc(T_WC) - E_PW - 1));
  localparam int E_WRS = E_SU + E_PW + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0] rd_data, mem_dout;
  logic [7:0] mem_din;
  logic [16:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS), .T_RC_NS(T_RC), .T_WC_NS(T_WC), .T_PWE_NS(T_PWE),
              .T_SD_NS(T_SD), .T_OE_NS(T_OE), .T_AW_NS(T_AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din));

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [16:0] a);
    return a[7:0] ^ {a[16:15], a[13:8]} ^ 8'h5A;
  endfunction

  logic [7:0] store [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] store_rd(input logic [16:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  always @(mem_addr, mem_oe_n, mem_we_n, mem_ce1_n, mem_ce2, n_tests)
    mem_din = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ? store_rd(mem_addr) : 8'hEE;

  logic [7:0] cur_wdata = '0;
  int sel_run = 0, oe_run = 0, we_run = 0, den_run = 0, rv_run = 0;
  bit run_wr = 0, addr_moved = 0, oe_bad = 0, fight = 0, prev_we_low = 0;
  logic [16:0] run_addr = '0;

  always @(negedge clk) if (rst_n) begin
    automatic bit sel = !mem_ce1_n && mem_ce2;
    if (req_ready)
      check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en, "R1 idle pins",
            {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);
    if (mem_dout_en && (!mem_oe_n || !sel)) fight = 1;
    if (sel) begin
      if (sel_run == 0) run_addr = mem_addr;
      else if (mem_addr != run_addr) addr_moved = 1;
      sel_run++;
      if (!mem_we_n) run_wr = 1;
      if (!mem_we_n && !mem_oe_n) oe_bad = 1;
    end else if (sel_run > 0) begin
      if (run_wr) begin
        check(sel_run == E_WRS, "R7 write select length", sel_run, E_WRS);
        check(!oe_bad, "R5 OE high during WE low", oe_bad, 0);
      end else
        check(sel_run == E_RD, "R3 read select length", sel_run, E_RD);
      check(!addr_moved, "R3 address stable", addr_moved, 0);
      check(!fight, "R9 no drive with OE low or deselected", fight, 0);
      sel_run = 0; run_wr = 0; addr_moved = 0; oe_bad = 0; fight = 0;
    end
    if (!mem_oe_n) oe_run++;
    else if (oe_run > 0) begin
      check(oe_run == E_RD, "R3 OE low length", oe_run, E_RD);
      check(rd_valid, "R4 valid in first OE-high cycle", rd_valid, 1);
      oe_run = 0;
    end
    if (!mem_we_n) we_run++;
    else if (we_run > 0) begin
      check(we_run == E_PW, "R5 WE low length", we_run, E_PW);
      we_run = 0;
    end
    if (prev_we_low && mem_we_n) begin
      check(sel && mem_dout_en, "R6 enables held at WE rise", {sel, mem_dout_en}, 2'b11);
      check(mem_dout == cur_wdata, "R2 write data captured", mem_dout, cur_wdata);
      store[int'(mem_addr)] = mem_dout;
    end
    prev_we_low = !mem_we_n;
    if (mem_dout_en) den_run++;
    else if (den_run > 0) begin
      check(den_run == E_PW + 1, "R6 drive length", den_run, E_PW + 1);
      den_run = 0;
    end
    if (rd_valid) rv_run++;
    else if (rv_run > 0) begin
      check(rv_run == 1, "R4 valid pulse width", rv_run, 1);
      rv_run = 0;
    end
  end

  bit last_wr = 0;

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) cur_wdata = d;
    @(negedge clk);
    check(!req_ready, "R2 ready low after accept", req_ready, 0);
    req_valid = 0; req_write = !wr; req_addr = ~a; req_wdata = ~d;
    lat = 1;
    while (mem_ce1_n && lat < 10) begin @(negedge clk); lat++; end
    check(lat == ((wr != last_wr) ? 2 : 1), "R8 select latency", lat, (wr != last_wr) ? 2 : 1);
    if (wr) begin
      ref_mem[int'(a)] = d;
      while (!req_ready) @(negedge clk);
    end else begin
      while (!rd_valid) @(negedge clk);
      check(rd_data == ref_rd(a), "R4 read data", rd_data, ref_rd(a));
      @(negedge clk);
    end
    last_wr = wr;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dout_en, "R1 reset pins",
          {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);
    check(req_ready && !rd_valid, "R1 reset handshake", {req_ready, rd_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    do_req(0, 17'h00010, 8'h00);
    do_req(1, 17'h00000, 8'h3C);
    do_req(1, 17'h1FFFF, 8'hA5);
    do_req(0, 17'h1FFFF, 8'h00);
    do_req(0, 17'h00000, 8'h00);
    do_req(0, 17'h0ABCD, 8'h00);
    do_req(1, 17'h0ABCD, 8'hFF);
    do_req(1, 17'h0ABCD, 8'h00);
    do_req(0, 17'h0ABCD, 8'h00);
    for (int i = 0; i < 80; i++) begin
      automatic logic [16:0] a = ($urandom % 4 == 0) ? 17'($urandom) : 17'($urandom % 12);
      do_req(bit'($urandom % 2), a, 8'($urandom));
    end
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule